// File: doc/BRIEF.md
# Serial Command Decoder for a Wiper Register Space

This block is a serial-peripheral slave that turns a stream of command bytes into register accesses on a space of sixteen addresses. Each command starts with a header byte that carries a four-bit address, a two-bit opcode and two data bits. Write and read commands add a data byte. Increment and decrement commands are a single byte. The block does not hold the registers. It raises one-cycle load, increment and decrement strobes toward external wiper registers and reads the addressed value back on a read-data input. While a header is arriving it shifts status out, and during a read it shifts the register contents out.

All logic runs on one system clock. The serial clock, serial data, chip-select-active level and high-voltage flag arrive already synchronised to that clock. Serial data is taken on each rising serial-clock edge and the output changes on each falling edge. The serial clock may idle low or high. Commands may follow one another with no gap while chip select stays active. An invalid address or opcode raises an error flag that holds until chip select is released.

Top module: `spi_cmd_top`

## Requirements
- R1: After reset, `sdo` is 1, `cmdErr` is 0 and all three strobes are 0.
- R2: `sdi` is sampled on the rising edge of `sck` and `sdo` changes only on a falling edge of `sck` that follows a rising edge in the current selection. Both idle levels of `sck` work the same way.
- R3: The header byte arrives MSB first as address[3:0], opcode[1:0], an unused bit and then data bit 8. `regAddr` takes the address after the sixth rising edge of the header.
- R4: Opcode 00 is a 16-bit write. `wrData` = {header bit 8, data byte}, and `wrStb` pulses for one clock, two clocks after the 16th rising `sck` edge is seen. At most one strobe is high in any cycle.
- R5: Opcode 11 is a 16-bit read. `sdo` carries bit 8 of `rdData` during the eighth header bit, then bits 7..0 MSB first during the data byte.
- R6: Opcode 01 (increment) and opcode 10 (decrement) are 8-bit commands. Their strobe pulses two clocks after the eighth rising edge, and the next bit starts a new command.
- R7: An increment is not strobed when the addressed value is at or above full scale (256). A decrement is not strobed when the value is 0 or above 256.
- R8: During a header, `sdo` is 1 for the first six bits and equals the error flag during the seventh bit. During the eighth bit and the data byte of any command other than a valid read, `sdo` is 1.
- R9: With the default masks, a write or read to an address above 5, or an increment or decrement to an address above 1, sets `cmdErr`. The flag stays set and blocks every strobe and all read data until chip select goes inactive.
- R10: While `csActive` is low, the error flag and the bit position clear and `sdo` returns to 1. A command cut short by deselection has no effect.
- R11: Commands of any mix follow one another within one selection with no idle bits between them.
- R12: `hvMode` has no effect on decoding. Its value at the header's sixth rising edge appears on `hvCmd`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rstN | input | 1 | Asynchronous active-low reset |
| csActive | input | 1 | Synchronised chip-select-active level |
| hvMode | input | 1 | Marks the current selection as high-voltage mode |
| sck | input | 1 | Synchronised serial clock |
| sdi | input | 1 | Synchronised serial data in |
| rdData | input | 9 | Value of the register at `regAddr` |
| sdo | output | 1 | Serial data out (idles 1) |
| regAddr | output | 4 | Address of the current command |
| wrStb | output | 1 | One-cycle write strobe |
| incStb | output | 1 | One-cycle increment strobe |
| decStb | output | 1 | One-cycle decrement strobe |
| wrData | output | 9 | Write value, valid with `wrStb` |
| hvCmd | output | 1 | High-voltage flag of the current command |
| cmdErr | output | 1 | Sticky command error flag |

## Verification
Writes and reads are sent with the serial clock idling low and then idling high. Because a read returns a value written in the other mode, a fault in edge handling in either mode shows up. Increment, decrement, read and write are mixed in a single selection, so a wrong command length misaligns every command that follows. Writes that place the register at 0, 256 and 300, each followed by an increment or decrement, separate the saturation limits. An invalid command followed by a valid one in the same selection, and a header cut off by deselection, check that the error is sticky and that deselection resets the bit position. A behavioural model compares every output on every clock.

// File: rtl/spi_cmd_pkg.sv
package spi_cmd_pkg;
  localparam int ADDR_W = 4;
  localparam int BYTE_W = 8;
  localparam int DATA_W = BYTE_W + 1;
  localparam int CNT_W  = $clog2(2 * BYTE_W);
  localparam int REGS   = 1 << ADDR_W;

  typedef enum logic [1:0] {
    OP_WRITE = 2'b00,
    OP_INC   = 2'b01,
    OP_DEC   = 2'b10,
    OP_READ  = 2'b11
  } spiOp_e;

  typedef enum logic [1:0] {
    TX_ONE,
    TX_ERR,
    TX_RDHI,
    TX_SHIFT
  } txSel_e;

  typedef struct packed {
    logic   clrAll;
    logic   shiftIn;
    logic   capHdr;
    logic   capD8;
    logic   txUpd;
    txSel_e txSel;
    logic   errBit;
    logic   fireWr;
    logic   fireInc;
    logic   fireDec;
  } dpCtl_t;
endpackage

// File: rtl/spi_cmd_ctrl.sv
module spi_cmd_ctrl
  import spi_cmd_pkg::*;
#(
  parameter int FULL_SCALE = 256,
  parameter logic [REGS-1:0] RW_MASK = 16'h003F,
  parameter logic [REGS-1:0] WIPER_MASK = 16'h0003
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              csActive,
  input  logic              sck,
  input  logic              sdi,
  input  logic [4:0]        rxBits,
  input  logic [DATA_W-1:0] rdData,
  output dpCtl_t            ctl,
  output logic              errFlag
);
  localparam logic [DATA_W-1:0] FULL_V = DATA_W'(FULL_SCALE);
  localparam logic [CNT_W-1:0]  HDR_LAST = CNT_W'(BYTE_W - 1);
  localparam logic [CNT_W-1:0]  OP_BIT   = CNT_W'(5);
  localparam logic [CNT_W-1:0]  ERR_BIT  = CNT_W'(6);
  localparam logic [CNT_W-1:0]  CMD_LAST = CNT_W'(2 * BYTE_W - 1);

  logic             sckQ;
  logic [CNT_W-1:0] bitCnt;
  logic             anyRise;
  logic             errQ;
  spiOp_e           opQ;

  logic             rise, fall;
  logic [ADDR_W-1:0] hdrAddr;
  spiOp_e           hdrOp;
  logic             hdrBad;
  logic             shortCmd, readOk, incOk, decOk;

  assign rise     = csActive && sck && !sckQ;
  assign fall     = csActive && !sck && sckQ;
  assign hdrAddr  = rxBits[4:1];
  assign hdrOp    = spiOp_e'({rxBits[0], sdi});
  assign hdrBad   = (hdrOp == OP_INC || hdrOp == OP_DEC) ? !WIPER_MASK[hdrAddr]
                                                         : !RW_MASK[hdrAddr];
  assign shortCmd = (opQ == OP_INC) || (opQ == OP_DEC);
  assign readOk   = (opQ == OP_READ) && !errQ;
  assign incOk    = rdData < FULL_V;
  assign decOk    = (rdData != '0) && (rdData <= FULL_V);
  assign errFlag  = errQ;

  always_comb begin
    ctl        = '0;
    ctl.txSel  = TX_ONE;
    ctl.clrAll = !csActive;
    ctl.errBit = errQ;
    if (rise) begin
      ctl.shiftIn = 1'b1;
      ctl.capHdr  = (bitCnt == OP_BIT);
      ctl.capD8   = (bitCnt == HDR_LAST);
      ctl.fireInc = (bitCnt == HDR_LAST) && (opQ == OP_INC) && !errQ && incOk;
      ctl.fireDec = (bitCnt == HDR_LAST) && (opQ == OP_DEC) && !errQ && decOk;
      ctl.fireWr  = (bitCnt == CMD_LAST) && (opQ == OP_WRITE) && !errQ;
    end
    if (fall && anyRise) begin
      ctl.txUpd = 1'b1;
      if (bitCnt == ERR_BIT)       ctl.txSel = TX_ERR;
      else if (bitCnt == HDR_LAST) ctl.txSel = readOk ? TX_RDHI : TX_ONE;
      else if (bitCnt > HDR_LAST)  ctl.txSel = readOk ? TX_SHIFT : TX_ONE;
      else                         ctl.txSel = TX_ONE;
    end
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      sckQ    <= 1'b0;
      bitCnt  <= '0;
      anyRise <= 1'b0;
      errQ    <= 1'b0;
      opQ     <= OP_WRITE;
    end else begin
      sckQ <= sck;
      if (!csActive) begin
        bitCnt  <= '0;
        anyRise <= 1'b0;
        errQ    <= 1'b0;
      end else if (rise) begin
        anyRise <= 1'b1;
        if (bitCnt == OP_BIT) begin
          opQ <= hdrOp;
          if (hdrBad) errQ <= 1'b1;
        end
        if ((bitCnt == HDR_LAST && shortCmd) || bitCnt == CMD_LAST) bitCnt <= '0;
        else bitCnt <= bitCnt + 1'b1;
      end
    end
  end

  // R10
  cnt_clear_chk: assert property (@(posedge clk) disable iff (!rstN)
    !csActive |=> (bitCnt == '0 && !errQ));

  // R9
  err_sticky_chk: assert property (@(posedge clk) disable iff (!rstN)
    (errQ && csActive) |=> errQ);
endmodule

// File: rtl/spi_cmd_dp.sv
module spi_cmd_dp
  import spi_cmd_pkg::*;
(
  input  logic              clk,
  input  logic              rstN,
  input  dpCtl_t            ctl,
  input  logic              sdi,
  input  logic              hvMode,
  input  logic [DATA_W-1:0] rdData,
  output logic [4:0]        rxBits,
  output logic              sdo,
  output logic [ADDR_W-1:0] regAddr,
  output logic              wrStb,
  output logic              incStb,
  output logic              decStb,
  output logic [DATA_W-1:0] wrData,
  output logic              hvCmd
);
  logic [BYTE_W-2:0] rxShift;
  logic [BYTE_W-1:0] txShift;
  logic              d8Q;

  assign rxBits = rxShift[4:0];

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      rxShift <= '0;
      txShift <= '1;
      d8Q     <= 1'b0;
      sdo     <= 1'b1;
      regAddr <= '0;
      wrStb   <= 1'b0;
      incStb  <= 1'b0;
      decStb  <= 1'b0;
      wrData  <= '0;
      hvCmd   <= 1'b0;
    end else begin
      wrStb  <= ctl.fireWr;
      incStb <= ctl.fireInc;
      decStb <= ctl.fireDec;
      if (ctl.shiftIn) rxShift <= {rxShift[BYTE_W-3:0], sdi};
      if (ctl.capHdr) begin
        regAddr <= rxShift[4:1];
        hvCmd   <= hvMode;
      end
      if (ctl.capD8) d8Q <= sdi;
      if (ctl.fireWr) wrData <= {d8Q, rxShift, sdi};
      if (ctl.clrAll) begin
        sdo <= 1'b1;
      end else if (ctl.txUpd) begin
        case (ctl.txSel)
          TX_ERR:  sdo <= ctl.errBit;
          TX_RDHI: begin
            sdo     <= rdData[DATA_W-1];
            txShift <= rdData[BYTE_W-1:0];
          end
          TX_SHIFT: begin
            sdo     <= txShift[BYTE_W-1];
            txShift <= {txShift[BYTE_W-2:0], 1'b1};
          end
          default: sdo <= 1'b1;
        endcase
      end
    end
  end

  // R4
  one_strobe_chk: assert property (@(posedge clk) disable iff (!rstN)
    $onehot0({wrStb, incStb, decStb}));

  // R4
  wr_pulse_chk: assert property (@(posedge clk) disable iff (!rstN)
    wrStb |=> !wrStb);

  // R10
  idle_high_chk: assert property (@(posedge clk) disable iff (!rstN)
    ctl.clrAll |=> sdo);

  // R3
  addr_hold_chk: assert property (@(posedge clk) disable iff (!rstN)
    !ctl.capHdr |=> $stable(regAddr));
endmodule

// File: rtl/spi_cmd_top.sv
module spi_cmd_top
  import spi_cmd_pkg::*;
#(
  parameter int FULL_SCALE = 256,
  parameter logic [15:0] RW_MASK = 16'h003F,
  parameter logic [15:0] WIPER_MASK = 16'h0003
) (
  input  logic       clk,
  input  logic       rstN,
  input  logic       csActive,
  input  logic       hvMode,
  input  logic       sck,
  input  logic       sdi,
  input  logic [8:0] rdData,
  output logic       sdo,
  output logic [3:0] regAddr,
  output logic       wrStb,
  output logic       incStb,
  output logic       decStb,
  output logic [8:0] wrData,
  output logic       hvCmd,
  output logic       cmdErr
);
  dpCtl_t     ctl;
  logic [4:0] rxBits;

  spi_cmd_ctrl #(
    .FULL_SCALE(FULL_SCALE),
    .RW_MASK(RW_MASK),
    .WIPER_MASK(WIPER_MASK)
  ) uCtrl (
    .clk(clk), .rstN(rstN), .csActive(csActive), .sck(sck), .sdi(sdi),
    .rxBits(rxBits), .rdData(rdData), .ctl(ctl), .errFlag(cmdErr)
  );

  spi_cmd_dp uDp (
    .clk(clk), .rstN(rstN), .ctl(ctl), .sdi(sdi), .hvMode(hvMode),
    .rdData(rdData), .rxBits(rxBits), .sdo(sdo), .regAddr(regAddr),
    .wrStb(wrStb), .incStb(incStb), .decStb(decStb), .wrData(wrData),
    .hvCmd(hvCmd)
  );
endmodule

// File: tb/sim_spi_cmd_top.sv
`timescale 1ns/1ps
module sim_spi_cmd_top;
  logic clk = 1'b0;
  logic rstN = 1'b0;
  logic cs = 1'b0, hv = 1'b0, sck = 1'b0, sdi = 1'b0;
  logic [8:0] rdData;
  logic sdo, wrStb, incStb, decStb, hvCmd, cmdErr;
  logic [3:0] regAddr;
  logic [8:0] wrData;
  int checks = 0, failures = 0;

  always #5 clk = ~clk;

  spi_cmd_top u0 (
    .clk(clk), .rstN(rstN), .csActive(cs), .hvMode(hv), .sck(sck), .sdi(sdi),
    .rdData(rdData), .sdo(sdo), .regAddr(regAddr), .wrStb(wrStb),
    .incStb(incStb), .decStb(decStb), .wrData(wrData), .hvCmd(hvCmd),
    .cmdErr(cmdErr)
  );

  // external wiper registers driven by the strobes
  logic [8:0] regFile [16];
  assign rdData = regFile[regAddr];
  always @(posedge clk) begin
    if (!rstN) begin
      for (int i = 0; i < 16; i++) regFile[i] <= '0;
    end else begin
      if (wrStb)  regFile[regAddr] <= wrData;
      if (incStb) regFile[regAddr] <= regFile[regAddr] + 9'd1;
      if (decStb) regFile[regAddr] <= regFile[regAddr] - 9'd1;
    end
  end

  task automatic check(input bit ok, input string what, input int act, input int exp);
    checks++;
    if (!ok) begin
      failures++;
      $display("FAIL %s actual=%0d expected=%0d", what, act, exp);
    end
  endtask

  // behavioural reference model
  int  mm [16];
  int  mIdx, mWord, mD8, mOp, mSnap, eAddr, eWrData;
  bit  mSck, mSeen, mErr, eSdo, eWr, eInc, eDec, eHv;
  always @(posedge clk) begin
    bit rise, fall, bad;
    if (!rstN) begin
      foreach (mm[i]) mm[i] = 0;
      mIdx = 0; mWord = 0; mD8 = 0; mOp = 0; mSnap = 0; eAddr = 0; eWrData = 0;
      mSck = 0; mSeen = 0; mErr = 0; eSdo = 1; eWr = 0; eInc = 0; eDec = 0; eHv = 0;
    end else begin
      if (eWr)  mm[eAddr] = eWrData;
      if (eInc) mm[eAddr] = mm[eAddr] + 1;
      if (eDec) mm[eAddr] = mm[eAddr] - 1;
      eWr = 0; eInc = 0; eDec = 0;
      rise = cs && sck && !mSck;
      fall = cs && !sck && mSck;
      mSck = sck;
      if (!cs) begin
        mIdx = 0; mErr = 0; mSeen = 0; eSdo = 1;
      end else if (rise) begin
        mSeen = 1;
        if (mIdx == 0) mWord = 0;
        mWord = mWord * 2 + int'(sdi);
        if (mIdx == 5) begin
          eAddr = (mWord >> 2) & 15;
          mOp = mWord & 3;
          eHv = hv;
          bad = (mOp == 1 || mOp == 2) ? (eAddr >= 2) : (eAddr >= 6);
          if (bad) mErr = 1;
        end
        if (mIdx == 7) begin
          mD8 = int'(sdi);
          if (mOp == 1 && !mErr && mm[eAddr] < 256) eInc = 1;
          if (mOp == 2 && !mErr && mm[eAddr] > 0 && mm[eAddr] <= 256) eDec = 1;
        end
        if (mIdx == 15 && mOp == 0 && !mErr) begin
          eWr = 1;
          eWrData = mD8 * 256 + (mWord & 255);
        end
        mIdx = ((mIdx == 7 && (mOp == 1 || mOp == 2)) || mIdx == 15) ? 0 : mIdx + 1;
      end else if (fall && mSeen) begin
        if (mIdx == 6) eSdo = mErr;
        else if (mIdx == 7 && mOp == 3 && !mErr) begin
          mSnap = mm[eAddr];
          eSdo = ((mSnap >> 8) & 1) != 0;
        end else if (mIdx >= 8 && mOp == 3 && !mErr) eSdo = ((mSnap >> (15 - mIdx)) & 1) != 0;
        else eSdo = 1;
      end
    end
  end

  // cycle-by-cycle comparison
  always @(negedge clk) begin
    if (rstN) begin
      check(sdo == eSdo, "R2/R5/R8 sdo", int'(sdo), int'(eSdo));
      check(wrStb == eWr, "R4 wrStb", int'(wrStb), int'(eWr));
      check(incStb == eInc, "R6/R7 incStb", int'(incStb), int'(eInc));
      check(decStb == eDec, "R6/R7 decStb", int'(decStb), int'(eDec));
      check(int'(wrData) == eWrData, "R4 wrData", int'(wrData), eWrData);
      check(int'(regAddr) == eAddr, "R3 regAddr", int'(regAddr), eAddr);
      check(hvCmd == eHv, "R12 hvCmd", int'(hvCmd), int'(eHv));
      check(cmdErr == mErr, "R9/R10 cmdErr", int'(cmdErr), int'(mErr));
    end
  end

  task automatic tick(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic xferBit(input bit b, output bit got);
    sck = 1'b0; sdi = b;
    tick(4);
    got = sdo;
    sck = 1'b1;
    tick(4);
  endtask

  task automatic beginFrame(input bit idleHigh, input bit hvf);
    sck = idleHigh; hv = hvf;
    tick(3);
    cs = 1'b1;
    tick(4);
  endtask

  task automatic endFrame(input bit idleHigh);
    if (!idleHigh) begin sck = 1'b0; tick(4); end
    cs = 1'b0;
    tick(4);
  endtask

  task automatic sendCmd(input int addr, input int op, input int data, output int got);
    bit [7:0] hdr;
    bit g;
    hdr = {addr[3:0], op[1:0], 1'b0, data[8]};
    got = 0;
    for (int i = 7; i >= 0; i--) begin xferBit(hdr[i], g); got = got * 2 + int'(g); end
    if (op == 0 || op == 3)
      for (int i = 7; i >= 0; i--) begin xferBit(data[i], g); got = got * 2 + int'(g); end
  endtask

  int g;
  initial begin
    tick(4);
    // R1 reset state
    check(sdo == 1'b1, "R1 sdo after reset", int'(sdo), 1);
    check(cmdErr == 1'b0, "R1 cmdErr after reset", int'(cmdErr), 0);
    check({wrStb, incStb, decStb} == 3'b000, "R1 strobes after reset", int'({wrStb, incStb, decStb}), 0);
    rstN = 1'b1;
    tick(4);

    // R4 write with sck idling low
    beginFrame(0, 0); sendCmd(0, 0, 421, g); endFrame(0);
    check(regFile[0] == 9'd421, "R4 write value", int'(regFile[0]), 421);

    // R2 R5 R8 read with sck idling high
    beginFrame(1, 0); sendCmd(0, 3, 0, g); endFrame(1);
    check((g & 511) == 421, "R5 read data", g & 511, 421);
    check((g >> 10) == 63, "R8 leading ones", g >> 10, 63);
    check(((g >> 9) & 1) == 0, "R8 error bit clear", (g >> 9) & 1, 0);

    // R6 R11 back-to-back mixed commands
    beginFrame(0, 0);
    sendCmd(1, 1, 0, g); sendCmd(1, 1, 0, g); sendCmd(1, 1, 0, g);
    check(((g >> 2) == 63) && ((g & 3) == 1), "R8 short command status", g, 253);
    sendCmd(1, 3, 0, g);
    check((g & 511) == 3, "R6 three increments", g & 511, 3);
    sendCmd(1, 2, 0, g); sendCmd(1, 3, 0, g);
    check((g & 511) == 2, "R11 decrement after read", g & 511, 2);
    endFrame(0);

    // R7 saturation limits
    beginFrame(1, 0);
    sendCmd(1, 0, 0, g);   sendCmd(1, 2, 0, g); sendCmd(1, 3, 0, g);
    check((g & 511) == 0, "R7 decrement at zero", g & 511, 0);
    sendCmd(1, 0, 256, g); sendCmd(1, 1, 0, g); sendCmd(1, 3, 0, g);
    check((g & 511) == 256, "R7 increment at full scale", g & 511, 256);
    sendCmd(1, 0, 300, g); sendCmd(1, 2, 0, g); sendCmd(1, 3, 0, g);
    check((g & 511) == 300, "R7 decrement above full scale", g & 511, 300);
    sendCmd(1, 0, 256, g); sendCmd(1, 2, 0, g); sendCmd(1, 3, 0, g);
    check((g & 511) == 255, "R7 decrement from full scale", g & 511, 255);
    endFrame(1);

    // R9 sticky error
    beginFrame(0, 0);
    sendCmd(3, 1, 0, g);
    check(((g >> 1) & 1) == 1, "R9 error bit on sdo", (g >> 1) & 1, 1);
    check(cmdErr == 1'b1, "R9 cmdErr set", int'(cmdErr), 1);
    sendCmd(0, 0, 7, g);
    check(regFile[0] == 9'd421, "R9 write blocked after error", int'(regFile[0]), 421);
    endFrame(0);
    check(cmdErr == 1'b0, "R10 cmdErr cleared", int'(cmdErr), 0);
    beginFrame(0, 0); sendCmd(9, 0, 5, g); endFrame(0);
    check(regFile[9] == 9'd0, "R9 write to invalid address", int'(regFile[9]), 0);
    beginFrame(0, 0); sendCmd(0, 0, 7, g); endFrame(0);
    check(regFile[0] == 9'd7, "R10 write after reselect", int'(regFile[0]), 7);

    // R12 high-voltage flag, R3 address
    beginFrame(1, 1); sendCmd(2, 0, 77, g);
    check(hvCmd == 1'b1, "R12 hvCmd reported", int'(hvCmd), 1);
    check(regAddr == 4'd2, "R3 address captured", int'(regAddr), 2);
    endFrame(1);
    check(regFile[2] == 9'd77, "R12 write in high-voltage mode", int'(regFile[2]), 77);

    // R10 aborted header
    beginFrame(0, 0);
    for (int i = 0; i < 5; i++) begin bit b; xferBit(1'b1, b); end
    endFrame(0);
    beginFrame(0, 0); sendCmd(0, 0, 12, g); endFrame(0);
    check(regFile[0] == 9'd12, "R10 aborted command ignored", int'(regFile[0]), 12);

    tick(4);
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

  initial begin
    repeat (150000) @(posedge clk);
    failures++;
    $display("FAIL watchdog expired actual=1 expected=0");
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end
endmodule